// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one programmable logic cell of the kind that sits behind a product-term array. Five product terms arrive from outside. A static configuration word decides how they are used: which terms feed a sum, how that sum is inverted or combined by XOR, and which terms act as the clock, the clock enable, the clear, the preset, the set/reset inputs of the storage element and the foldback term. A cascade input from the neighbouring cell is merged into the sum, and the merged sum is driven out again, so cells can be chained into wide sum-of-products functions.

The storage element can act as a D, T, JK or SR flip-flop, or as a transparent latch. All of its clocks are handled as ordinary signals and sampled by the system clock `clk`. A rising level seen on the selected clock counts as an edge. The clear and preset controls override the element on the next system clock edge. The output and the buried feedback each choose, independently of each other, between the stored value and the combinational XOR result. The output enable is picked from constants or from two enable inputs, in true or inverted form.

The configuration word has the layout of the packed type `mc_cfg_t` in the package. Its fields are named in the requirements below. An index that names a product term beyond the last one (5, 6 or 7) always reads as 0.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst` is high at a `clk` edge, the stored value is cleared, so that a registered output (`out_reg`=1) reads 0 after reset.
- R2: `cas_out` is the OR of `cas_in` and of every `pt_in[i]` whose `sum_mask[i]` is 1. Terms whose mask bit is 0 have no effect on it.
- R3: The combinational result is the sum XOR a second operand. The second operand is set by `xor_sel`: 0 gives constant 0 (true polarity), 1 gives constant 1 (inverted), and 2 gives `pt_in[xor_pt]`.
- R4: `fold_n_out` is the inverse of `pt_in[fold_pt]`, and it is 1 when `fold_pt` is out of range.
- R5: The data input of the storage element is set by `d_src`: 0 takes the combinational result, 1 takes `pt_in[d_pt]`, and 2 takes `pin_in`.
- R6: The `mode` field selects the element. In mode 0 (D) the element loads the data, and in mode 1 (T) it inverts when the data is 1. Either load happens only at a rising level of the selected clock, and the new value is visible one `clk` edge after that level is first sampled. A clock held high, or held low, causes no change.
- R7: In mode 2 (JK), J=`pt_in[set_pt]` and K=`pt_in[clr_pt]`: 00 holds, 10 sets, 01 clears and 11 toggles. In mode 3 (SR), with S and R taken from the same terms: 10 sets, 01 clears, and 00 or 11 holds.
- R8: In mode 4 (latch), the element follows the data at every `clk` edge at which the selected clock is high. It holds its value while that clock is low.
- R9: `clk_sel` values 0 to 2 select `gclk_in[clk_sel]`, and value 3 selects `pt_in[clk_pt]`. Clocks that are not selected have no effect.
- R10: With `ce_en`=1 and a global clock selected, clock events are ignored while `pt_in[ce_pt]` is 0. With the product-term clock selected, `ce_en` has no effect.
- R11: `ar_sel` picks the clear: 0 never, 1 `gclr_in`, 2 `pt_in[ar_pt]`, 3 either one. With `ap_en`=1, `pt_in[ap_pt]` presets the element. Clear beats preset, and both beat any clock event, taking effect at the next `clk` edge.
- R12: `mc_out` shows the stored value when `out_reg`=1 and the combinational result otherwise. `fb_out` makes the same choice independently through `fb_reg`.
- R13: `mc_oe` is set by `oe_sel`: 0 gives 0, 1 gives 1, 2 gives `oe_in[0]`, 3 gives its inverse, 4 gives `oe_in[1]` and 5 gives its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every input |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | CFG_W | Static configuration, laid out as `mc_cfg_t` |
| pt_in | input | 5 | Product terms from the array |
| cas_in | input | 1 | Sum term from the neighbouring cell |
| pin_in | input | 1 | Pin input value |
| gclk_in | input | 3 | Global clocks, sampled as levels |
| gclr_in | input | 1 | Global clear |
| oe_in | input | 2 | Output-enable inputs |
| mc_out | output | 1 | Cell output |
| mc_oe | output | 1 | Output enable |
| fb_out | output | 1 | Buried feedback |
| fold_n_out | output | 1 | Inverted foldback term |
| cas_out | output | 1 | Merged sum for the next cell |

## Verification
The hardest situations to reach are those in which two controls of the storage element compete in the same cycle. Examples are a clear and a preset together, an asynchronous control arriving on the same cycle as a clock rise, and a clock enable that is low while the product-term clock is selected. Each task first sets the element to a known value with a clock pulse. It then raises the competing inputs in one drive, so that they are sampled at the same `clk` edge. A clock held high over several cycles while the data changes shows that only rising levels load the element.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

  parameter int NUM_PT   = 5;
  parameter int NUM_GCLK = 3;
  parameter int NUM_OE   = 2;

  localparam int PTI_W = $clog2(NUM_PT);
  localparam int CKS_W = $clog2(NUM_GCLK + 1);
  localparam logic [PTI_W-1:0] PT_LAST   = PTI_W'(NUM_PT - 1);
  localparam logic [CKS_W-1:0] GCLK_LAST = CKS_W'(NUM_GCLK - 1);

  typedef enum logic [1:0] {XP_ZERO = 2'd0, XP_ONE = 2'd1, XP_TERM = 2'd2, XP_RSVD = 2'd3} mc_xor_e;
  typedef enum logic [1:0] {DS_XOR = 2'd0, DS_TERM = 2'd1, DS_PIN = 2'd2, DS_RSVD = 2'd3} mc_dsrc_e;
  typedef enum logic [2:0] {MD_D = 3'd0, MD_T = 3'd1, MD_JK = 3'd2, MD_SR = 3'd3,
                            MD_LATCH = 3'd4, MD_R5 = 3'd5, MD_R6 = 3'd6, MD_R7 = 3'd7} mc_mode_e;
  typedef enum logic [1:0] {AR_NONE = 2'd0, AR_GCLR = 2'd1, AR_TERM = 2'd2, AR_BOTH = 2'd3} mc_ar_e;
  typedef enum logic [2:0] {OE_OFF = 3'd0, OE_ON = 3'd1, OE_A = 3'd2, OE_A_N = 3'd3,
                            OE_B = 3'd4, OE_B_N = 3'd5, OE_R6 = 3'd6, OE_R7 = 3'd7} mc_oe_e;

  typedef struct packed {
    logic [NUM_PT-1:0] sum_mask;
    mc_xor_e           xor_sel;
    logic [PTI_W-1:0]  xor_pt;
    mc_dsrc_e          d_src;
    logic [PTI_W-1:0]  d_pt;
    mc_mode_e          mode;
    logic [PTI_W-1:0]  set_pt;
    logic [PTI_W-1:0]  clr_pt;
    logic [CKS_W-1:0]  clk_sel;
    logic [PTI_W-1:0]  clk_pt;
    logic              ce_en;
    logic [PTI_W-1:0]  ce_pt;
    mc_ar_e            ar_sel;
    logic [PTI_W-1:0]  ar_pt;
    logic              ap_en;
    logic [PTI_W-1:0]  ap_pt;
    logic              out_reg;
    logic              fb_reg;
    logic [PTI_W-1:0]  fold_pt;
    mc_oe_e            oe_sel;
  } mc_cfg_t;

  localparam int CFG_W = $bits(mc_cfg_t);

  // Selects one product term; an index past the last term reads as 0.
  function automatic logic pt_pick(input logic [NUM_PT-1:0] v, input logic [PTI_W-1:0] idx);
    return (idx <= PT_LAST) ? v[idx] : 1'b0;
  endfunction

endpackage

// File: rtl/pld_mc_terms.sv
module pld_mc_terms
  import pld_mc_pkg::*;
(
  input  logic [NUM_PT-1:0] pt,
  input  logic              cas_in,
  input  logic              pin,
  input  logic [NUM_PT-1:0] sum_mask,
  input  mc_xor_e           xor_sel,
  input  logic [PTI_W-1:0]  xor_pt,
  input  mc_dsrc_e          d_src,
  input  logic [PTI_W-1:0]  d_pt,
  input  logic [PTI_W-1:0]  set_pt,
  input  logic [PTI_W-1:0]  clr_pt,
  input  logic [PTI_W-1:0]  fold_pt,
  output logic              sum,
  output logic              xor_res,
  output logic              data,
  output logic              set_t,
  output logic              clr_t,
  output logic              fold_n
);

  logic [NUM_PT-1:0] steered;
  logic              xor_b;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_steer
    assign steered[g] = pt[g] & sum_mask[g];
  end

  assign sum = (|steered) | cas_in;

  always_comb begin
    case (xor_sel)
      XP_ZERO: xor_b = 1'b0;
      XP_ONE:  xor_b = 1'b1;
      XP_TERM: xor_b = pt_pick(pt, xor_pt);
      default: xor_b = 1'b0;
    endcase
  end

  assign xor_res = sum ^ xor_b;

  always_comb begin
    case (d_src)
      DS_XOR:  data = xor_res;
      DS_TERM: data = pt_pick(pt, d_pt);
      DS_PIN:  data = pin;
      default: data = xor_res;
    endcase
  end

  assign set_t  = pt_pick(pt, set_pt);
  assign clr_t  = pt_pick(pt, clr_pt);
  assign fold_n = ~pt_pick(pt, fold_pt);

endmodule

// File: rtl/pld_mc_ctrl.sv
module pld_mc_ctrl
  import pld_mc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PT-1:0]   pt,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                gclr,
  input  mc_mode_e            mode,
  input  logic [CKS_W-1:0]    clk_sel,
  input  logic [PTI_W-1:0]    clk_pt,
  input  logic                ce_en,
  input  logic [PTI_W-1:0]    ce_pt,
  input  mc_ar_e              ar_sel,
  input  logic [PTI_W-1:0]    ar_pt,
  input  logic                ap_en,
  input  logic [PTI_W-1:0]    ap_pt,
  output logic                upd,
  output logic                lat_open,
  output logic                arst,
  output logic                apre
);

  logic is_glob;
  logic sel_lvl;
  logic sel_prev;
  logic ce_ok;
  logic is_latch;

  assign is_glob  = (clk_sel <= GCLK_LAST);
  assign sel_lvl  = is_glob ? gclk[clk_sel] : pt_pick(pt, clk_pt);
  assign ce_ok    = !(is_glob && ce_en) || pt_pick(pt, ce_pt);
  assign is_latch = (mode == MD_LATCH);

  // Previous sampled level of the selected clock, for rise detection.
  always_ff @(posedge clk) begin
    if (rst) sel_prev <= 1'b0;
    else     sel_prev <= sel_lvl;
  end

  assign upd      = sel_lvl & ~sel_prev & ce_ok & ~is_latch;
  assign lat_open = sel_lvl & ce_ok & is_latch;

  always_comb begin
    case (ar_sel)
      AR_GCLR: arst = gclr;
      AR_TERM: arst = pt_pick(pt, ar_pt);
      AR_BOTH: arst = gclr | pt_pick(pt, ar_pt);
      default: arst = 1'b0;
    endcase
  end

  assign apre = ap_en & pt_pick(pt, ap_pt);

endmodule

// File: rtl/pld_mc_store.sv
module pld_mc_store
  import pld_mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mc_mode_e mode,
  input  logic     upd,
  input  logic     lat_open,
  input  logic     arst,
  input  logic     apre,
  input  logic     data,
  input  logic     set_t,
  input  logic     clr_t,
  output logic     state
);

  logic nxt;

  always_comb begin
    nxt = state;
    case (mode)
      MD_D: nxt = data;
      MD_T: nxt = state ^ data;
      MD_JK: begin
        case ({set_t, clr_t})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          2'b11:   nxt = ~state;
          default: nxt = state;
        endcase
      end
      MD_SR: begin
        case ({set_t, clr_t})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = state;
        endcase
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           state <= 1'b0;
    else if (arst)     state <= 1'b0;
    else if (apre)     state <= 1'b1;
    else if (upd)      state <= nxt;
    else if (lat_open) state <= data;
  end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic [NUM_PT-1:0]   pt_in,
  input  logic                cas_in,
  input  logic                pin_in,
  input  logic [NUM_GCLK-1:0] gclk_in,
  input  logic                gclr_in,
  input  logic [NUM_OE-1:0]   oe_in,
  output logic                mc_out,
  output logic                mc_oe,
  output logic                fb_out,
  output logic                fold_n_out,
  output logic                cas_out
);

  mc_cfg_t  cfg;
  mc_mode_e mode_w;
  logic     sum_w, xor_w, data_w, set_w, clr_w;
  logic     upd_w, lat_open_w, arst_w, apre_w, state_w;

  assign cfg    = mc_cfg_t'(cfg_word);
  assign mode_w = cfg.mode;

  pld_mc_terms u_terms (
    .pt(pt_in), .cas_in(cas_in), .pin(pin_in),
    .sum_mask(cfg.sum_mask), .xor_sel(cfg.xor_sel), .xor_pt(cfg.xor_pt),
    .d_src(cfg.d_src), .d_pt(cfg.d_pt), .set_pt(cfg.set_pt), .clr_pt(cfg.clr_pt),
    .fold_pt(cfg.fold_pt),
    .sum(sum_w), .xor_res(xor_w), .data(data_w), .set_t(set_w), .clr_t(clr_w),
    .fold_n(fold_n_out)
  );

  pld_mc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .pt(pt_in), .gclk(gclk_in), .gclr(gclr_in), .mode(mode_w),
    .clk_sel(cfg.clk_sel), .clk_pt(cfg.clk_pt), .ce_en(cfg.ce_en), .ce_pt(cfg.ce_pt),
    .ar_sel(cfg.ar_sel), .ar_pt(cfg.ar_pt), .ap_en(cfg.ap_en), .ap_pt(cfg.ap_pt),
    .upd(upd_w), .lat_open(lat_open_w), .arst(arst_w), .apre(apre_w)
  );

  pld_mc_store u_store (
    .clk(clk), .rst(rst), .mode(mode_w), .upd(upd_w), .lat_open(lat_open_w),
    .arst(arst_w), .apre(apre_w), .data(data_w), .set_t(set_w), .clr_t(clr_w),
    .state(state_w)
  );

  assign cas_out = sum_w;
  assign mc_out  = cfg.out_reg ? state_w : xor_w;
  assign fb_out  = cfg.fb_reg  ? state_w : xor_w;

  always_comb begin
    case (cfg.oe_sel)
      OE_OFF:  mc_oe = 1'b0;
      OE_ON:   mc_oe = 1'b1;
      OE_A:    mc_oe = oe_in[0];
      OE_A_N:  mc_oe = ~oe_in[0];
      OE_B:    mc_oe = oe_in[1];
      OE_B_N:  mc_oe = ~oe_in[1];
      default: mc_oe = 1'b0;
    endcase
  end

endmodule

// File: rtl/pld_macrocell_chk.sv
module pld_macrocell_chk
  import pld_mc_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input mc_mode_e mode,
  input logic     upd,
  input logic     lat_open,
  input logic     arst,
  input logic     apre,
  input logic     data,
  input logic     state
);

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> !state);

  assert_dmode_load_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_D && upd && !arst && !apre) |=> state == $past(data));

  assert_tmode_flip_R6: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_T && upd && data && !arst && !apre) |=> state != $past(state));

  assert_hold_no_event_R6: assert property (@(posedge clk) disable iff (rst)
    (!upd && !lat_open && !arst && !apre) |=> $stable(state));

  assert_latch_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (lat_open && !arst && !apre) |=> state == $past(data));

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (rst)
    arst |=> !state);

  assert_preset_sets_R11: assert property (@(posedge clk) disable iff (rst)
    (apre && !arst) |=> state);

endmodule

bind pld_macrocell pld_macrocell_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode_w), .upd(upd_w), .lat_open(lat_open_w),
  .arst(arst_w), .apre(apre_w), .data(data_w), .state(state_w)
);

// File: tb/pld_macrocell_bench.sv
module pld_macrocell_bench;
  import pld_mc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  mc_cfg_t cfg;
  logic [CFG_W-1:0] cfg_word;
  logic [NUM_PT-1:0] pt_in;
  logic cas_in, pin_in, gclr_in;
  logic [NUM_GCLK-1:0] gclk_in;
  logic [NUM_OE-1:0] oe_in;
  logic mc_out, mc_oe, fb_out, fold_n_out, cas_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  assign cfg_word = cfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_macrocell u_pld_macrocell (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .pt_in(pt_in), .cas_in(cas_in),
    .pin_in(pin_in), .gclk_in(gclk_in), .gclr_in(gclr_in), .oe_in(oe_in),
    .mc_out(mc_out), .mc_oe(mc_oe), .fb_out(fb_out), .fold_n_out(fold_n_out),
    .cas_out(cas_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse(input int idx);
    gclk_in[idx] = 1'b1;
    tick();
    gclk_in[idx] = 1'b0;
    tick();
  endtask

  task automatic base_cfg();
    cfg = '0;
    cfg.xor_sel = XP_ZERO;
    cfg.d_src   = DS_PIN;
    cfg.mode    = MD_D;
    cfg.ar_sel  = AR_NONE;
    cfg.out_reg = 1'b1;
    cfg.oe_sel  = OE_ON;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pt_in = '0; cas_in = 1'b0; pin_in = 1'b0; gclr_in = 1'b0;
    gclk_in = '0; oe_in = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    base_cfg();
    cfg.fb_reg = 1'b1;
    pin_in = 1'b1;
    pulse(0);
    do_reset();
    chk("R1 out after reset", mc_out, 1'b0);
    chk("R1 fb after reset", fb_out, 1'b0);
  endtask

  task automatic t_sum();
    base_cfg();
    cfg.sum_mask = 5'b00101;
    pt_in = 5'b00010; cas_in = 1'b0; settle();
    chk("R2 masked term ignored", cas_out, 1'b0);
    pt_in = 5'b00100; settle();
    chk("R2 enabled term", cas_out, 1'b1);
    pt_in = 5'b00000; cas_in = 1'b1; settle();
    chk("R2 cascade in", cas_out, 1'b1);
    cfg.sum_mask = 5'b11111; cas_in = 1'b0; pt_in = 5'b10000; settle();
    chk("R2 all five", cas_out, 1'b1);
    pt_in = '0; settle();
  endtask

  task automatic t_xor();
    base_cfg();
    cfg.out_reg = 1'b0; cfg.sum_mask = 5'b11111;
    pt_in = 5'b00001; settle();
    chk("R3 const0 polarity", mc_out, 1'b1);
    cfg.xor_sel = XP_ONE; settle();
    chk("R3 const1 polarity", mc_out, 1'b0);
    pt_in = 5'b00000; settle();
    chk("R3 const1 zero sum", mc_out, 1'b1);
    cfg.xor_sel = XP_TERM; cfg.xor_pt = 3'd4;
    pt_in = 5'b10001; settle();
    chk("R3 term xor 1^1", mc_out, 1'b0);
    pt_in = 5'b00001; settle();
    chk("R3 term xor 1^0", mc_out, 1'b1);
    pt_in = '0;
  endtask

  task automatic t_fold();
    base_cfg();
    cfg.fold_pt = 3'd2;
    pt_in = 5'b00100; settle();
    chk("R4 fold of one", fold_n_out, 1'b0);
    pt_in = 5'b11011; settle();
    chk("R4 fold of zero", fold_n_out, 1'b1);
    cfg.fold_pt = 3'd6; pt_in = 5'b11111; settle();
    chk("R4 fold out of range", fold_n_out, 1'b1);
    pt_in = '0;
  endtask

  task automatic t_dsrc();
    do_reset(); base_cfg();
    cfg.d_src = DS_XOR; cfg.sum_mask = 5'b00001;
    pt_in = 5'b00001; pulse(0);
    chk("R5 data from xor 1", mc_out, 1'b1);
    pt_in = 5'b00000; pulse(0);
    chk("R5 data from xor 0", mc_out, 1'b0);
    cfg.d_src = DS_TERM; cfg.d_pt = 3'd3;
    pt_in = 5'b01000; pulse(0);
    chk("R5 data from term", mc_out, 1'b1);
    cfg.d_src = DS_PIN; pin_in = 1'b0; pulse(0);
    chk("R5 data from pin 0", mc_out, 1'b0);
    pin_in = 1'b1; pulse(0);
    chk("R5 data from pin 1", mc_out, 1'b1);
    pt_in = '0;
  endtask

  task automatic t_dt();
    do_reset(); base_cfg();
    pin_in = 1'b1; gclk_in[0] = 1'b1; tick();
    chk("R6 D load on rise", mc_out, 1'b1);
    pin_in = 1'b0; tick(); tick();
    chk("R6 clock held high holds", mc_out, 1'b1);
    gclk_in[0] = 1'b0; tick();
    chk("R6 falling level holds", mc_out, 1'b1);
    gclk_in[0] = 1'b1; tick();
    chk("R6 next rise loads 0", mc_out, 1'b0);
    gclk_in[0] = 1'b0; tick();
    cfg.mode = MD_T; pin_in = 1'b1; pulse(0);
    chk("R6 T toggle up", mc_out, 1'b1);
    pulse(0);
    chk("R6 T toggle down", mc_out, 1'b0);
    pin_in = 1'b0; pulse(0);
    chk("R6 T zero holds", mc_out, 1'b0);
  endtask

  task automatic t_jk_sr();
    do_reset(); base_cfg();
    cfg.mode = MD_JK; cfg.set_pt = 3'd0; cfg.clr_pt = 3'd1;
    pt_in = 5'b00001; pulse(0);
    chk("R7 JK set", mc_out, 1'b1);
    pt_in = 5'b00000; pulse(0);
    chk("R7 JK hold", mc_out, 1'b1);
    pt_in = 5'b00010; pulse(0);
    chk("R7 JK clear", mc_out, 1'b0);
    pt_in = 5'b00011; pulse(0);
    chk("R7 JK toggle up", mc_out, 1'b1);
    pulse(0);
    chk("R7 JK toggle down", mc_out, 1'b0);
    cfg.mode = MD_SR;
    pt_in = 5'b00001; pulse(0);
    chk("R7 SR set", mc_out, 1'b1);
    pt_in = 5'b00011; pulse(0);
    chk("R7 SR both holds 1", mc_out, 1'b1);
    pt_in = 5'b00010; pulse(0);
    chk("R7 SR clear", mc_out, 1'b0);
    pt_in = 5'b00011; pulse(0);
    chk("R7 SR both holds 0", mc_out, 1'b0);
    pt_in = '0;
  endtask

  task automatic t_latch();
    do_reset(); base_cfg();
    cfg.mode = MD_LATCH; cfg.clk_sel = 2'd1;
    pin_in = 1'b1; tick();
    chk("R8 closed latch holds", mc_out, 1'b0);
    gclk_in[1] = 1'b1; tick();
    chk("R8 open latch passes 1", mc_out, 1'b1);
    pin_in = 1'b0; tick();
    chk("R8 open latch passes 0", mc_out, 1'b0);
    gclk_in[1] = 1'b0; pin_in = 1'b1; tick(); tick();
    chk("R8 latch holds when low", mc_out, 1'b0);
  endtask

  task automatic t_clksel();
    do_reset(); base_cfg();
    cfg.clk_sel = 2'd2; pin_in = 1'b1;
    pulse(0); pulse(1);
    chk("R9 unselected clocks ignored", mc_out, 1'b0);
    pulse(2);
    chk("R9 gclk2 selected", mc_out, 1'b1);
    cfg.clk_sel = 2'd3; cfg.clk_pt = 3'd4; pin_in = 1'b0;
    pulse(2);
    chk("R9 global ignored with term clock", mc_out, 1'b1);
    pt_in = 5'b10000; tick();
    chk("R9 term clock loads", mc_out, 1'b0);
    pt_in = '0; tick();
  endtask

  task automatic t_ce();
    do_reset(); base_cfg();
    cfg.ce_en = 1'b1; cfg.ce_pt = 3'd2; pin_in = 1'b1;
    pt_in = 5'b00000; pulse(0);
    chk("R10 enable low ignores edge", mc_out, 1'b0);
    pt_in = 5'b00100; pulse(0);
    chk("R10 enable high loads", mc_out, 1'b1);
    cfg.clk_sel = 2'd3; cfg.clk_pt = 3'd0; pin_in = 1'b0;
    pt_in = 5'b00001; tick();
    chk("R10 enable unused with term clock", mc_out, 1'b0);
    pt_in = '0; tick();
  endtask

  task automatic t_async();
    do_reset(); base_cfg();
    pin_in = 1'b1; pulse(0);
    cfg.ar_sel = AR_GCLR; gclr_in = 1'b1; tick();
    chk("R11 global clear", mc_out, 1'b0);
    gclr_in = 1'b0; pulse(0);
    cfg.ar_sel = AR_TERM; cfg.ar_pt = 3'd3; gclr_in = 1'b1; tick();
    chk("R11 global clear unselected", mc_out, 1'b1);
    gclr_in = 1'b0; pt_in = 5'b01000; tick();
    chk("R11 term clear", mc_out, 1'b0);
    pt_in = '0; pulse(0);
    cfg.ar_sel = AR_BOTH; gclr_in = 1'b1; tick();
    chk("R11 either clear via global", mc_out, 1'b0);
    gclr_in = 1'b0; pulse(0);
    pt_in = 5'b01000; tick();
    chk("R11 either clear via term", mc_out, 1'b0);
    pt_in = '0;
    cfg.ar_sel = AR_NONE; cfg.ap_en = 1'b1; cfg.ap_pt = 3'd1;
    pt_in = 5'b00010; tick();
    chk("R11 preset", mc_out, 1'b1);
    cfg.ar_sel = AR_GCLR; gclr_in = 1'b1; tick();
    chk("R11 clear beats preset", mc_out, 1'b0);
    pt_in = '0; gclr_in = 1'b0; cfg.ap_en = 1'b0; tick();
    gclr_in = 1'b1; gclk_in[0] = 1'b1; tick();
    chk("R11 clear beats clock rise", mc_out, 1'b0);
    gclr_in = 1'b0; gclk_in[0] = 1'b0; tick();
  endtask

  task automatic t_outfb();
    do_reset(); base_cfg();
    cfg.sum_mask = 5'b00001; pin_in = 1'b1; pulse(0);
    pt_in = 5'b00000; settle();
    chk("R12 out registered", mc_out, 1'b1);
    chk("R12 fb combinational", fb_out, 1'b0);
    cfg.out_reg = 1'b0; cfg.fb_reg = 1'b1; settle();
    chk("R12 out combinational", mc_out, 1'b0);
    chk("R12 fb registered", fb_out, 1'b1);
  endtask

  task automatic t_oe();
    base_cfg();
    oe_in = 2'b01;
    cfg.oe_sel = OE_OFF; settle(); chk("R13 off", mc_oe, 1'b0);
    cfg.oe_sel = OE_ON;  settle(); chk("R13 on", mc_oe, 1'b1);
    cfg.oe_sel = OE_A;   settle(); chk("R13 input A", mc_oe, 1'b1);
    cfg.oe_sel = OE_A_N; settle(); chk("R13 input A inverted", mc_oe, 1'b0);
    cfg.oe_sel = OE_B;   settle(); chk("R13 input B", mc_oe, 1'b0);
    cfg.oe_sel = OE_B_N; settle(); chk("R13 input B inverted", mc_oe, 1'b1);
  endtask

  initial begin
    base_cfg();
    do_reset();
    t_reset();
    t_sum();
    t_xor();
    t_fold();
    t_dsrc();
    t_dt();
    t_jk_sr();
    t_latch();
    t_clksel();
    t_ce();
    t_async();
    t_outfb();
    t_oe();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule